// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Wildcards

This block decides, once per one-second clock update, whether the running time of day has reached a programmed alarm time. It takes three running time bytes (seconds, minutes, hours) and three alarm bytes of the same kinds. When the update strobe is high, it compares each alarm byte with its time byte. If all three agree, it latches an alarm flag. The flag drives an interrupt line whenever the alarm-enable input is high.

Any alarm byte whose two top bits are both 1 (values C0h to FFh) is a wildcard and agrees with every value of its time byte. With no wildcard the alarm fires once a day. A wildcard in the hours byte makes it fire once an hour. Wildcards in hours and minutes make it fire once a minute. Wildcards in all three bytes make it fire on every update.

The comparison works on the raw bytes. For that reason the same logic serves BCD and binary counting and 12-hour and 24-hour formats without knowing which is in use. Reading the flag register, signalled by a one-cycle read strobe, clears the flag. Bus decoding and the time counters sit outside this block.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, `alm_flag` and `irq` are both 0.
- R2: When `upd_stb` is 1 in a cycle where every alarm byte equals its time byte, `alm_flag` reads 1 from the next clock edge onward.
- R3: Matching bytes with `upd_stb` at 0 leave `alm_flag` unchanged.
- R4: With `upd_stb` at 1, a difference in any single non-wildcard byte keeps `alm_flag` at 0.
- R5: An alarm byte with bits 7 and 6 both 1 (C0h–FFh) matches any time byte. An alarm byte with only one of those bits set (for example 80h or 40h) is compared exactly.
- R6: A wildcard hours byte gives a match for every hour. Wildcard hours and minutes give a match for every minute. Three wildcards give a match on every update.
- R7: Bit 7 of the hours bytes (the PM marker in 12-hour format) is part of the comparison: time 92h does not match alarm 12h, and it does match alarm 92h.
- R8: `alm_flag` is set on a match whatever the value of `alm_en`. `irq` is 0 whenever `alm_en` is 0.
- R9: `alm_flag` stays at 1 until a cycle with `flag_rd` at 1 clears it at the next edge. If a match with `upd_stb` lands in the same cycle as `flag_rd`, the flag stays 1.
- R10: `irq` equals `alm_flag` AND `alm_en` with no added cycle, so setting `alm_en` while the flag is pending raises `irq` at once, and clearing the flag drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | One-cycle strobe after the time bytes have advanced |
| sec_now | input | 8 | Running seconds byte |
| min_now | input | 8 | Running minutes byte |
| hr_now | input | 8 | Running hours byte (bit 7 = PM in 12-hour format) |
| sec_alm | input | 8 | Seconds alarm byte |
| min_alm | input | 8 | Minutes alarm byte |
| hr_alm | input | 8 | Hours alarm byte |
| alm_en | input | 1 | Alarm interrupt enable |
| flag_rd | input | 1 | One-cycle strobe: flag register is being read |
| alm_flag | output | 1 | Latched alarm flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench first presents an exact BCD time both without and with the update strobe, which separates the compare path from the strobe gating. It then puts an off-by-one value in each byte in turn, which shows that every byte takes part in the match. Alarm values C0h and FFh are set against values 80h and 40h in the hours byte, and stacked wildcards are tried with changing time values; together these show that the wildcard needs both top bits and that each repeat rate works. Last, PM-marked hours, toggling of the enable, and a read that coincides with a match show that raw-byte comparison is used, that the interrupt is gated, and that a set wins over a clear in the same cycle.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

   // Field order used to pack the time and alarm bytes internally
   typedef enum int unsigned {
      FLD_SEC = 0,
      FLD_MIN = 1,
      FLD_HR  = 2
   } tod_field_e;

   localparam int unsigned TOD_FIELDS = 3;

endpackage

// File: rtl/tod_alarm_field_cmp.sv
module tod_alarm_field_cmp #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WILD_BITS = 2
) (
   input  logic [DATA_W-1:0] now_i,
   input  logic [DATA_W-1:0] alm_i,
   output logic              hit_o
);

   localparam int unsigned TOP = DATA_W - 1;

   if (WILD_BITS == 0 || WILD_BITS > DATA_W) begin : g_bad_wild
      $error("tod_alarm_field_cmp: WILD_BITS must be 1..DATA_W");
   end

   logic wild;
   logic same;

   // wildcard when all top WILD_BITS bits are set
   assign wild  = &alm_i[TOP -: WILD_BITS];
   assign same  = (now_i == alm_i);
   assign hit_o = wild | same;

endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;

   // set has priority so a match landing on a read is not lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & en_i;

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
   import tod_alarm_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WILD_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_stb,
   input  logic [DATA_W-1:0] sec_now,
   input  logic [DATA_W-1:0] min_now,
   input  logic [DATA_W-1:0] hr_now,
   input  logic [DATA_W-1:0] sec_alm,
   input  logic [DATA_W-1:0] min_alm,
   input  logic [DATA_W-1:0] hr_alm,
   input  logic              alm_en,
   input  logic              flag_rd,
   output logic              alm_flag,
   output logic              irq
);

   localparam int unsigned NF = TOD_FIELDS;

   if (DATA_W < 2) begin : g_bad_width
      $error("tod_alarm_match: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] now_a [NF];
   logic [DATA_W-1:0] alm_a [NF];
   logic [NF-1:0]     hit;
   logic              match_set;

   assign now_a[FLD_SEC] = sec_now;
   assign now_a[FLD_MIN] = min_now;
   assign now_a[FLD_HR]  = hr_now;
   assign alm_a[FLD_SEC] = sec_alm;
   assign alm_a[FLD_MIN] = min_alm;
   assign alm_a[FLD_HR]  = hr_alm;

   for (genvar f = 0; f < NF; f++) begin : g_field
      tod_alarm_field_cmp #(
         .DATA_W    (DATA_W),
         .WILD_BITS (WILD_BITS)
      ) u_cmp (
         .now_i (now_a[f]),
         .alm_i (alm_a[f]),
         .hit_o (hit[f])
      );
   end

   assign match_set = upd_stb & (&hit);

   tod_alarm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (match_set),
      .clr_i  (flag_rd),
      .en_i   (alm_en),
      .flag_o (alm_flag),
      .irq_o  (irq)
   );

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WILD_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_stb,
   input logic [DATA_W-1:0] sec_now,
   input logic [DATA_W-1:0] min_now,
   input logic [DATA_W-1:0] hr_now,
   input logic [DATA_W-1:0] sec_alm,
   input logic [DATA_W-1:0] min_alm,
   input logic [DATA_W-1:0] hr_alm,
   input logic              alm_en,
   input logic              flag_rd,
   input logic              alm_flag,
   input logic              irq
);

   localparam int unsigned TOP = DATA_W - 1;

   logic sec_miss, min_miss, hr_miss, any_miss;

   assign sec_miss = !(&sec_alm[TOP -: WILD_BITS]) && (sec_alm != sec_now);
   assign min_miss = !(&min_alm[TOP -: WILD_BITS]) && (min_alm != min_now);
   assign hr_miss  = !(&hr_alm[TOP -: WILD_BITS])  && (hr_alm  != hr_now);
   assign any_miss = sec_miss | min_miss | hr_miss;

   AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && !any_miss |=> alm_flag); // R2

   AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_flag && !upd_stb |=> !alm_flag); // R3

   AST_NO_SET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_flag && any_miss |=> !alm_flag); // R4

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_en |-> !irq); // R8

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      alm_flag && !flag_rd |=> alm_flag); // R9

   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      flag_rd && !upd_stb |=> !alm_flag); // R9

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      alm_en && alm_flag |-> irq); // R10

endmodule

bind tod_alarm_match tod_alarm_chk #(
   .DATA_W    (DATA_W),
   .WILD_BITS (WILD_BITS)
) u_chk (.*);

// File: tb/sim_tod_alarm_match.sv
`timescale 1ns/1ps
module sim_tod_alarm_match;

   localparam int unsigned W = 8;
   localparam time         TCLK = 8ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         upd_stb = 1'b0;
   logic [W-1:0] sec_now = '0, min_now = '0, hr_now = '0;
   logic [W-1:0] sec_alm = '0, min_alm = '0, hr_alm = '0;
   logic         alm_en = 1'b0;
   logic         flag_rd = 1'b0;
   logic         alm_flag;
   logic         irq;

   int checks = 0;
   int errors = 0;

   always #(TCLK/2) clk = ~clk;

   tod_alarm_match u0 (
      .clk, .rst_n, .upd_stb,
      .sec_now, .min_now, .hr_now,
      .sec_alm, .min_alm, .hr_alm,
      .alm_en, .flag_rd, .alm_flag, .irq
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      hr_now = h; min_now = m; sec_now = s;
   endtask

   task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      hr_alm = h; min_alm = m; sec_alm = s;
   endtask

   // one update strobe; on return the flag edge has passed
   task automatic pulse_update();
      @(negedge clk); upd_stb = 1'b1;
      @(negedge clk); upd_stb = 1'b0;
   endtask

   task automatic pulse_read();
      @(negedge clk); flag_rd = 1'b1;
      @(negedge clk); flag_rd = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "flag after reset", alm_flag, 1'b0);
      check("R1", "irq after reset", irq, 1'b0);
   endtask

   task automatic t_exact();
      alm_en = 1'b1;
      set_alarm(8'h12, 8'h34, 8'h56);
      set_time(8'h12, 8'h34, 8'h56);
      repeat (3) @(negedge clk);
      check("R3", "match without strobe", alm_flag, 1'b0);
      pulse_update();
      check("R2", "exact match flag", alm_flag, 1'b1);
      check("R10", "irq with enable", irq, 1'b1);
      set_time(8'h12, 8'h34, 8'h57);
      pulse_update();
      check("R9", "flag held over later miss", alm_flag, 1'b1);
      pulse_read();
      check("R9", "flag cleared by read", alm_flag, 1'b0);
      check("R10", "irq drops with flag", irq, 1'b0);
   endtask

   task automatic t_miss();
      set_alarm(8'h12, 8'h34, 8'h56);
      set_time(8'h12, 8'h34, 8'h55); pulse_update();
      check("R4", "seconds differ", alm_flag, 1'b0);
      set_time(8'h12, 8'h35, 8'h56); pulse_update();
      check("R4", "minutes differ", alm_flag, 1'b0);
      set_time(8'h13, 8'h34, 8'h56); pulse_update();
      check("R4", "hours differ", alm_flag, 1'b0);
   endtask

   task automatic t_wild();
      set_alarm(8'hC0, 8'h10, 8'h20);
      for (int h = 0; h < 3; h++) begin
         set_time(8'(h * 7), 8'h10, 8'h20); pulse_update();
         check("R6", "hourly wildcard hit", alm_flag, 1'b1);
         pulse_read();
      end
      set_time(8'h05, 8'h11, 8'h20); pulse_update();
      check("R6", "hourly wildcard minute miss", alm_flag, 1'b0);
      set_alarm(8'h80, 8'h10, 8'h20);
      set_time(8'h05, 8'h10, 8'h20); pulse_update();
      check("R5", "80h is not wildcard", alm_flag, 1'b0);
      set_alarm(8'h40, 8'h10, 8'h20); pulse_update();
      check("R5", "40h is not wildcard", alm_flag, 1'b0);
      set_alarm(8'hFF, 8'hE3, 8'h20);
      set_time(8'h21, 8'h47, 8'h20); pulse_update();
      check("R6", "per-minute wildcard hit", alm_flag, 1'b1);
      pulse_read();
      set_time(8'h21, 8'h47, 8'h21); pulse_update();
      check("R6", "per-minute seconds miss", alm_flag, 1'b0);
      set_alarm(8'hC5, 8'hFF, 8'hD0);
      for (int s = 0; s < 3; s++) begin
         set_time(8'h09, 8'(s + 3), 8'(s * 17)); pulse_update();
         check("R6", "every-update wildcard hit", alm_flag, 1'b1);
         pulse_read();
      end
   endtask

   task automatic t_pm();
      set_alarm(8'h12, 8'h00, 8'h00);
      set_time(8'h92, 8'h00, 8'h00); pulse_update();
      check("R7", "PM time vs AM alarm", alm_flag, 1'b0);
      set_alarm(8'h92, 8'h00, 8'h00); pulse_update();
      check("R7", "PM time vs PM alarm", alm_flag, 1'b1);
      pulse_read();
      set_alarm(8'h17, 8'h3B, 8'h3A);
      set_time(8'h17, 8'h3B, 8'h3A); pulse_update();
      check("R7", "binary 24h raw match", alm_flag, 1'b1);
      pulse_read();
   endtask

   task automatic t_enable();
      alm_en = 1'b0;
      set_alarm(8'h01, 8'h02, 8'h03);
      set_time(8'h01, 8'h02, 8'h03); pulse_update();
      check("R8", "flag set while disabled", alm_flag, 1'b1);
      check("R8", "irq low while disabled", irq, 1'b0);
      alm_en = 1'b1; #1;
      check("R10", "irq on enable", irq, 1'b1);
      alm_en = 1'b0; #1;
      check("R8", "irq off on disable", irq, 1'b0);
      pulse_read();
      alm_en = 1'b1; #1;
      check("R10", "no irq after clear", irq, 1'b0);
   endtask

   task automatic t_race();
      set_alarm(8'h01, 8'h02, 8'h03);
      set_time(8'h01, 8'h02, 8'h03);
      @(negedge clk); upd_stb = 1'b1; flag_rd = 1'b1;
      @(negedge clk); upd_stb = 1'b0; flag_rd = 1'b0;
      check("R9", "set wins over read", alm_flag, 1'b1);
      pulse_read();
      check("R9", "later read clears", alm_flag, 1'b0);
   endtask

   initial begin
      #(TCLK * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_miss();
      t_wild();
      t_pm();
      t_enable();
      t_race();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule